// File: doc/BRIEF.md
# Fast System-Call Privilege Transition Unit

This unit models the architectural state changes that a 64-bit core makes when it executes a fast kernel-entry or fast kernel-exit instruction. It holds a small bank of model-specific registers: a feature-control word, a selector word, the kernel entry address, a spare entry address and a flag-clear mask. The core reads and writes this bank through a 32-bit indexed port.

A call or return request commits in a single clock edge. That edge updates the instruction pointer, the flags, the return-address and saved-flags registers, the code and stack selectors, and the current privilege level. No descriptor table is read. Selectors follow fixed adjacency offsets from a base, and flags are cleared through the programmable mask.

A request that is not legal commits nothing. Instead it raises one of two fault pulses: invalid-opcode or protection. The core can also load its architectural registers directly through a load strobe, which stands in for ordinary instruction writes to those registers.

Top module: `fc_unit`

## Requirements
- R1: After reset, every register in the bank, rip, rflags, rcx, r11, csSel and ssSel read zero, cpl reads 0, and both fault outputs are low.
- R2: The bank is indexed as follows. 0xC0000080 is the feature word, 0xC0000081 the selector word, 0xC0000082 the entry address, 0xC0000083 the spare entry address and 0xC0000084 the mask. A write to any other index changes nothing, and a read of any other index returns zero. Reads are combinational.
- R3: The feature word keeps only bit 0 (call enable), bit 8 (long-mode enable), bit 10 (long-mode active) and bit 11 (no-execute enable). All other feature bits, and mask bits [63:32], read back as zero.
- R4: A call or return when feature bit 0 is 0, feature bit 10 is 0 or cs64 is 0 pulses udFault for one cycle and changes no architectural state.
- R5: A legal-mode call when cpl is not 3, or a legal-mode return when cpl is not 0, pulses gpFault for one cycle and changes no architectural state. udFault takes precedence, and the two faults never assert together.
- R6: A legal call copies rip into rcx, loads rip from the entry address and sets cpl to 0, all on the next edge.
- R7: A legal call copies rflags into r11. The new rflags is the old value with every bit cleared where mask bits [31:0] are 1.
- R8: A legal call sets csSel to selector-word bits [47:32] and ssSel to that value plus 8.
- R9: A legal return loads rip from rcx and rflags from r11, and sets cpl to 3. rcx and r11 keep their values.
- R10: A legal return takes a base from selector-word bits [63:48]. When retLong=1, csSel = base+16 and ssSel = base+8. When retLong=0, csSel = base and ssSel = base+8. Both selectors have bits [1:0] forced to 3. Selector-word bits [31:0] have no effect.
- R11: When callReq and retReq are both high, only the call is performed. Any request takes priority over archWr.
- R12: archWr with no request loads rip, rflags, rcx, r11, csSel, ssSel and cpl from the ld* inputs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regIdx | input | 32 | Register bank index |
| regWrEn | input | 1 | Register bank write strobe |
| regWrData | input | 64 | Register bank write data |
| regRdData | output | 64 | Register bank read data (combinational) |
| cs64 | input | 1 | Current code segment is 64-bit |
| callReq | input | 1 | Fast call request |
| retReq | input | 1 | Fast return request |
| retLong | input | 1 | Return to 64-bit code (1) or 32-bit code (0) |
| archWr | input | 1 | Direct load of architectural state |
| ldRip | input | 64 | Load value for rip |
| ldFlags | input | 64 | Load value for rflags |
| ldRcx | input | 64 | Load value for rcx |
| ldR11 | input | 64 | Load value for r11 |
| ldCs | input | 16 | Load value for csSel |
| ldSs | input | 16 | Load value for ssSel |
| ldCpl | input | 2 | Load value for cpl |
| rip | output | 64 | Instruction pointer |
| rflags | output | 64 | Flags |
| rcx | output | 64 | Return-address register |
| r11 | output | 64 | Saved-flags register |
| csSel | output | 16 | Code selector |
| ssSel | output | 16 | Stack selector |
| cpl | output | 2 | Current privilege level |
| udFault | output | 1 | Invalid-opcode fault pulse |
| gpFault | output | 1 | Protection fault pulse |

## Verification
The bench builds the unit at its default widths: a 64-bit register file and a 32-bit flag mask. At these widths the reserved upper half of the mask can be written with ones and is seen to read back as zero and to leave rflags alone. Random selector bases include values near the top of the 16-bit range, so the +8 and +16 offsets wrap. The low bits of the base are random, so the forced privilege bits show up against arbitrary values.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [31:0] IDX_FEAT  = 32'hC000_0080;
  localparam logic [31:0] IDX_SEL   = 32'hC000_0081;
  localparam logic [31:0] IDX_ENTRY = 32'hC000_0082;
  localparam logic [31:0] IDX_SPARE = 32'hC000_0083;
  localparam logic [31:0] IDX_MASK  = 32'hC000_0084;

  localparam int FEAT_CALLEN = 0;
  localparam int FEAT_LMEN   = 8;
  localparam int FEAT_LMACT  = 10;
  localparam int FEAT_NXEN   = 11;

  localparam int SEL_W = 16;
  localparam int CALL_SEL_LSB = 32;
  localparam int RET_SEL_LSB  = 48;

  localparam logic [1:0] PL_KERNEL = 2'd0;
  localparam logic [1:0] PL_USER   = 2'd3;

  typedef struct packed {
    logic doCall;
    logic doRet;
    logic retLong;
    logic doLoad;
  } fcStrobe_t;
endpackage

// File: rtl/fc_msr_bank.sv
module fc_msr_bank #(
  parameter int XLEN   = 64,
  parameter int MASK_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     regIdx,
  input  logic            regWrEn,
  input  logic [XLEN-1:0] regWrData,
  output logic [XLEN-1:0] regRdData,
  output logic            featCallEn,
  output logic            featLmAct,
  output logic [XLEN-1:0] selWord,
  output logic [XLEN-1:0] entryAddr,
  output logic [XLEN-1:0] flagMask
);
  import fc_pkg::*;

  localparam logic [XLEN-1:0] FEAT_KEEP =
    (XLEN'(1) << FEAT_CALLEN) | (XLEN'(1) << FEAT_LMEN) |
    (XLEN'(1) << FEAT_LMACT)  | (XLEN'(1) << FEAT_NXEN);

  logic [XLEN-1:0]   featReg, selReg, entryReg, spareReg;
  logic [MASK_W-1:0] maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featReg  <= '0;
      selReg   <= '0;
      entryReg <= '0;
      spareReg <= '0;
      maskReg  <= '0;
    end else if (regWrEn) begin
      unique case (regIdx)
        IDX_FEAT:  featReg  <= regWrData & FEAT_KEEP;
        IDX_SEL:   selReg   <= regWrData;
        IDX_ENTRY: entryReg <= regWrData;
        IDX_SPARE: spareReg <= regWrData;
        IDX_MASK:  maskReg  <= regWrData[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (MASK_W < XLEN) begin : g_maskPad
      assign flagMask = {{(XLEN-MASK_W){1'b0}}, maskReg};
    end else begin : g_maskFull
      assign flagMask = maskReg[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    unique case (regIdx)
      IDX_FEAT:  regRdData = featReg;
      IDX_SEL:   regRdData = selReg;
      IDX_ENTRY: regRdData = entryReg;
      IDX_SPARE: regRdData = spareReg;
      IDX_MASK:  regRdData = flagMask;
      default:   regRdData = '0;
    endcase
  end

  assign featCallEn = featReg[FEAT_CALLEN];
  assign featLmAct  = featReg[FEAT_LMACT];
  assign selWord    = selReg;
  assign entryAddr  = entryReg;

  assert_feat_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    (featReg & ~FEAT_KEEP) == '0);
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callReq,
  input  logic             retReq,
  input  logic             retLong,
  input  logic             archWr,
  input  logic             featCallEn,
  input  logic             featLmAct,
  input  logic             cs64,
  input  logic [1:0]       cpl,
  output fc_pkg::fcStrobe_t strobe,
  output logic             udFault,
  output logic             gpFault
);
  import fc_pkg::*;

  logic reqAny, modeOk, plOk, udNext, gpNext;

  always_comb begin
    reqAny = callReq | retReq;
    modeOk = featCallEn & featLmAct & cs64;
    plOk   = callReq ? (cpl == PL_USER) : (cpl == PL_KERNEL);
    udNext = reqAny & ~modeOk;
    gpNext = reqAny & modeOk & ~plOk;

    strobe         = '0;
    strobe.doCall  = callReq & modeOk & plOk;
    strobe.doRet   = ~callReq & retReq & modeOk & plOk;
    strobe.retLong = retLong;
    strobe.doLoad  = archWr & ~reqAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      udFault <= 1'b0;
      gpFault <= 1'b0;
    end else begin
      udFault <= udNext;
      gpFault <= gpNext;
    end
  end

  assert_one_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({udFault, gpFault}));
  assert_call_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doCall && strobe.doRet));
  assert_ud_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqAny && !modeOk) |=> udFault);
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  fc_pkg::fcStrobe_t strobe,
  input  logic [XLEN-1:0]   selWord,
  input  logic [XLEN-1:0]   entryAddr,
  input  logic [XLEN-1:0]   flagMask,
  input  logic [XLEN-1:0]   ldRip,
  input  logic [XLEN-1:0]   ldFlags,
  input  logic [XLEN-1:0]   ldRcx,
  input  logic [XLEN-1:0]   ldR11,
  input  logic [15:0]       ldCs,
  input  logic [15:0]       ldSs,
  input  logic [1:0]        ldCpl,
  output logic [XLEN-1:0]   rip,
  output logic [XLEN-1:0]   rflags,
  output logic [XLEN-1:0]   rcx,
  output logic [XLEN-1:0]   r11,
  output logic [15:0]       csSel,
  output logic [15:0]       ssSel,
  output logic [1:0]        cpl
);
  import fc_pkg::*;

  localparam logic [SEL_W-1:0] STEP = SEL_W'(8);

  logic [SEL_W-1:0] callBase, retBase, callSs, retCs, retSs;

  always_comb begin
    callBase = selWord[CALL_SEL_LSB +: SEL_W];
    retBase  = selWord[RET_SEL_LSB +: SEL_W];
    callSs   = callBase + STEP;
    retCs    = (strobe.retLong ? retBase + (STEP << 1) : retBase) | SEL_W'(PL_USER);
    retSs    = (retBase + STEP) | SEL_W'(PL_USER);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rip    <= '0;
      rflags <= '0;
      rcx    <= '0;
      r11    <= '0;
      csSel  <= '0;
      ssSel  <= '0;
      cpl    <= PL_KERNEL;
    end else if (strobe.doCall) begin
      rcx    <= rip;
      rip    <= entryAddr;
      r11    <= rflags;
      rflags <= rflags & ~flagMask;
      csSel  <= callBase;
      ssSel  <= callSs;
      cpl    <= PL_KERNEL;
    end else if (strobe.doRet) begin
      rip    <= rcx;
      rflags <= r11;
      csSel  <= retCs;
      ssSel  <= retSs;
      cpl    <= PL_USER;
    end else if (strobe.doLoad) begin
      rip    <= ldRip;
      rflags <= ldFlags;
      rcx    <= ldRcx;
      r11    <= ldR11;
      csSel  <= ldCs;
      ssSel  <= ldSs;
      cpl    <= ldCpl;
    end
  end

  assert_call_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCall |=> (cpl == PL_KERNEL) && (rip == $past(entryAddr)) && (rcx == $past(rip)));
  assert_call_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCall |=> (rflags & $past(flagMask)) == '0);
  assert_ret_rpl_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRet |=> (cpl == PL_USER) && (csSel[1:0] == 2'b11) && (ssSel[1:0] == 2'b11));
  assert_ret_restore_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRet |=> (rip == $past(rcx)) && (rflags == $past(r11)));
endmodule

// File: rtl/fc_unit.sv
module fc_unit #(
  parameter int XLEN   = 64,
  parameter int MASK_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     regIdx,
  input  logic            regWrEn,
  input  logic [XLEN-1:0] regWrData,
  output logic [XLEN-1:0] regRdData,
  input  logic            cs64,
  input  logic            callReq,
  input  logic            retReq,
  input  logic            retLong,
  input  logic            archWr,
  input  logic [XLEN-1:0] ldRip,
  input  logic [XLEN-1:0] ldFlags,
  input  logic [XLEN-1:0] ldRcx,
  input  logic [XLEN-1:0] ldR11,
  input  logic [15:0]     ldCs,
  input  logic [15:0]     ldSs,
  input  logic [1:0]      ldCpl,
  output logic [XLEN-1:0] rip,
  output logic [XLEN-1:0] rflags,
  output logic [XLEN-1:0] rcx,
  output logic [XLEN-1:0] r11,
  output logic [15:0]     csSel,
  output logic [15:0]     ssSel,
  output logic [1:0]      cpl,
  output logic            udFault,
  output logic            gpFault
);
  import fc_pkg::*;

  fcStrobe_t       strobe;
  logic            featCallEn, featLmAct;
  logic [XLEN-1:0] selWord, entryAddr, flagMask;

  fc_msr_bank #(.XLEN(XLEN), .MASK_W(MASK_W)) u_bank (
    .clk, .rstN, .regIdx, .regWrEn, .regWrData, .regRdData,
    .featCallEn, .featLmAct, .selWord, .entryAddr, .flagMask
  );

  fc_ctrl u_ctrl (
    .clk, .rstN, .callReq, .retReq, .retLong, .archWr,
    .featCallEn, .featLmAct, .cs64, .cpl, .strobe, .udFault, .gpFault
  );

  fc_datapath #(.XLEN(XLEN)) u_dp (
    .clk, .rstN, .strobe, .selWord, .entryAddr, .flagMask,
    .ldRip, .ldFlags, .ldRcx, .ldR11, .ldCs, .ldSs, .ldCpl,
    .rip, .rflags, .rcx, .r11, .csSel, .ssSel, .cpl
  );

  assert_fault_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (udFault || gpFault) |-> $stable(rip) && $stable(rflags) && $stable(cpl) && $stable(csSel));
endmodule

// File: tb/fc_unit_tb.sv
module fc_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] regIdx = '0;
  logic regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic cs64 = 1'b0, callReq = 1'b0, retReq = 1'b0, retLong = 1'b0, archWr = 1'b0;
  logic [63:0] ldRip = '0, ldFlags = '0, ldRcx = '0, ldR11 = '0;
  logic [15:0] ldCs = '0, ldSs = '0;
  logic [1:0]  ldCpl = '0;
  logic [63:0] rip, rflags, rcx, r11;
  logic [15:0] csSel, ssSel;
  logic [1:0]  cpl;
  logic udFault, gpFault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model
  logic [63:0] mFeat, mSel, mEntry, mSpare, mMask;
  logic [63:0] mRip, mFlags, mRcx, mR11;
  logic [15:0] mCs, mSs;
  logic [1:0]  mCpl;
  logic mUd, mGp;

  always #10 clk = ~clk;

  fc_unit u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] readModel(input logic [31:0] idx);
    case (idx)
      32'hC000_0080: return mFeat;
      32'hC000_0081: return mSel;
      32'hC000_0082: return mEntry;
      32'hC000_0083: return mSpare;
      32'hC000_0084: return mMask;
      default:       return 64'd0;
    endcase
  endfunction

  task automatic modelReset();
    mFeat = '0; mSel = '0; mEntry = '0; mSpare = '0; mMask = '0;
    mRip = '0; mFlags = '0; mRcx = '0; mR11 = '0; mCs = '0; mSs = '0; mCpl = 2'd0;
    mUd = 1'b0; mGp = 1'b0;
  endtask

  // Advance the model by one edge using the inputs currently driven
  task automatic modelStep();
    logic modeOk, plOk;
    logic [15:0] b;
    mUd = 1'b0; mGp = 1'b0;
    modeOk = mFeat[0] && mFeat[10] && cs64;
    plOk = callReq ? (mCpl == 2'd3) : (mCpl == 2'd0);
    if (callReq || retReq) begin
      if (!modeOk) mUd = 1'b1;
      else if (!plOk) mGp = 1'b1;
      else if (callReq) begin
        mRcx = mRip; mRip = mEntry; mR11 = mFlags;
        mFlags = mFlags & ~{32'd0, mMask[31:0]};
        mCs = mSel[47:32]; mSs = mSel[47:32] + 16'd8; mCpl = 2'd0;
      end else begin
        b = mSel[63:48];
        mRip = mRcx; mFlags = mR11;
        mCs = (retLong ? b + 16'd16 : b) | 16'd3;
        mSs = (b + 16'd8) | 16'd3; mCpl = 2'd3;
      end
    end else if (archWr) begin
      mRip = ldRip; mFlags = ldFlags; mRcx = ldRcx; mR11 = ldR11;
      mCs = ldCs; mSs = ldSs; mCpl = ldCpl;
    end
    if (regWrEn) begin
      case (regIdx)
        32'hC000_0080: mFeat = regWrData & 64'h0D01;
        32'hC000_0081: mSel = regWrData;
        32'hC000_0082: mEntry = regWrData;
        32'hC000_0083: mSpare = regWrData;
        32'hC000_0084: mMask = {32'd0, regWrData[31:0]};
        default: ;
      endcase
    end
  endtask

  task automatic checkState(input string req);
    check({req, " rip"}, rip, mRip);
    check({req, " rflags"}, rflags, mFlags);
    check({req, " rcx"}, rcx, mRcx);
    check({req, " r11"}, r11, mR11);
    check({req, " csSel"}, {48'd0, csSel}, {48'd0, mCs});
    check({req, " ssSel"}, {48'd0, ssSel}, {48'd0, mSs});
    check({req, " cpl"}, {62'd0, cpl}, {62'd0, mCpl});
    check({req, " udFault"}, {63'd0, udFault}, {63'd0, mUd});
    check({req, " gpFault"}, {63'd0, gpFault}, {63'd0, mGp});
  endtask

  task automatic idle();
    regWrEn = 1'b0; callReq = 1'b0; retReq = 1'b0; archWr = 1'b0;
  endtask

  // Inputs driven at negedge; one edge; check at next negedge
  task automatic step(input string req);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    idle();
    checkState(req);
  endtask

  task automatic wrReg(input logic [31:0] idx, input logic [63:0] d, input string req);
    regIdx = idx; regWrEn = 1'b1; regWrData = d;
    step(req);
    #1;
    check({req, " readback"}, regRdData, readModel(idx));
  endtask

  task automatic load(input logic [63:0] r, f, c, e, input logic [15:0] cs, ss,
                      input logic [1:0] pl, input string req);
    ldRip = r; ldFlags = f; ldRcx = c; ldR11 = e; ldCs = cs; ldSs = ss; ldCpl = pl;
    archWr = 1'b1;
    step(req);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkState("R1");
    for (int k = 0; k < 5; k++) begin
      regIdx = 32'hC000_0080 + 32'(k); #1;
      check("R1 bank zero", regRdData, 64'd0);
    end

    // R2/R3 directed
    wrReg(32'hC000_0080, 64'hFFFF_FFFF_FFFF_FFFF, "R3 feature keep");
    wrReg(32'hC000_0084, 64'hFFFF_FFFF_0000_0200, "R3 mask upper");
    wrReg(32'hC000_0083, 64'h1111_2222_3333_4444, "R2 spare");
    wrReg(32'hC000_007F, 64'hDEAD_BEEF_0000_0001, "R2 unmapped");
    for (int k = 0; k < 5; k++) begin
      regIdx = 32'hC000_0080 + 32'(k); #1;
      check("R2 map", regRdData, readModel(regIdx));
    end
    regIdx = 32'hC000_0085; #1;
    check("R2 unmapped read", regRdData, 64'd0);

    wrReg(32'hC000_0081, 64'hFFF8_0010_FFFF_FFFF, "R10 sel");
    wrReg(32'hC000_0082, 64'hFFFF_8000_0000_1000, "R6 entry");

    // R7: mask upper-half ones must not clear flag bits 63:32
    load(64'h40_0000, 64'hFFFF_FFFF_0000_0202, 64'h0, 64'h0, 16'h33, 16'h2B, 2'd3, "R12 load");
    cs64 = 1'b1; callReq = 1'b1; step("R6 R7 R8 call");
    retReq = 1'b1; retLong = 1'b1; step("R9 R10 ret64 wrap");
    callReq = 1'b1; retReq = 1'b1; step("R11 both");
    retReq = 1'b1; retLong = 1'b0; step("R10 ret32");
    retReq = 1'b1; step("R5 ret from user");
    cs64 = 1'b0; callReq = 1'b1; step("R4 not 64-bit");
    cs64 = 1'b1; callReq = 1'b1; archWr = 1'b1; ldCpl = 2'd1; step("R11 req beats load");
    wrReg(32'hC000_0080, 64'h0000_0000_0000_0D00, "R4 disable");
    callReq = 1'b1; step("R4 disabled");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      cs64 = ($urandom_range(0, 9) != 0);
      retLong = $urandom_range(0, 1) == 1;
      case (op)
        0, 1: begin
          regIdx = 32'hC000_007E + 32'($urandom_range(0, 7));
          regWrEn = 1'b1;
          regWrData = r64();
          if (regIdx == 32'hC000_0080 && $urandom_range(0, 3) != 0) regWrData[10] = 1'b1;
          if (regIdx == 32'hC000_0080 && $urandom_range(0, 3) != 0) regWrData[0] = 1'b1;
          step("R2 R3 rand write");
          #1;
          check("R2 rand readback", regRdData, readModel(regIdx));
        end
        2: begin
          ldRip = r64(); ldFlags = r64(); ldRcx = r64(); ldR11 = r64();
          ldCs = 16'($urandom()); ldSs = 16'($urandom());
          ldCpl = ($urandom_range(0, 1) == 1) ? 2'd3 : 2'(($urandom_range(0, 3)));
          archWr = 1'b1;
          step("R12 rand load");
        end
        3, 4, 5: begin callReq = 1'b1; archWr = ($urandom_range(0, 3) == 0); step("R6 R7 R8 R4 R5 rand call"); end
        6, 7, 8: begin retReq = 1'b1; step("R9 R10 R4 R5 rand ret"); end
        default: begin callReq = 1'b1; retReq = 1'b1; step("R11 rand both"); end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule